// File: doc/BRIEF.md
# Deferred Power-State Request Dispatcher

This block turns device-state requests from the operating system into work for two child sequencers. A request to enter D3 either starts a full power-off or starts entry into a shallow idle state. A later request to return to D0 either starts the full power-on or starts exit from the idle state. The choice depends on a defer flag and on two type codes. Software arms each D3 request through a one-shot arm bit. A D0 request does nothing unless a D3 request acted before it.

Requests arrive as single-cycle pulses. Each one lands in a one-entry slot, and a small state machine takes it from there. If the firmware-owner input is high, the machine first pulses a configuration save (on the D3 path) or a configuration restore (on the D0 path). It then pulses exactly one start strobe and waits for the done pulse from the sequencer it started. Requests that arrive during that wait replace whatever the slot already holds.

Top module: `dpd_dispatch`

## Requirements
- R1: A D3 request acts only while the arm bit is set. Acting clears the arm bit, so a second D3 request without a new `arm_set_i` pulse starts nothing and pulses no save strobe.
- R2: A D3 request that acts sets `d0_pending_o`. A D0 request acts only while `d0_pending_o` is high, and acting clears it. A D0 request with the flag low starts nothing and pulses no restore strobe.
- R3: A D3 request that acts with the defer flag set starts idle entry when `entry_type_i` equals ENTRY_A (default 1) or ENTRY_B (default 2). For any other code it starts nothing. With the defer flag clear, it starts full power-off.
- R4: A D0 request that acts with the defer flag set starts idle exit when `exit_type_i` equals EXIT_CODE (default 3). For any other code it starts nothing. The defer flag is cleared in both cases. With the defer flag clear, it starts full power-on.
- R5: A D3 request never changes the defer flag, so a flag set before one D3 still steers the next D3.
- R6: When a request acts and `fw_owner_i` is high, a one-cycle `cfg_save_o` (D3) or `cfg_restore_o` (D0) pulse comes exactly one cycle before the start strobe slot. The pulse fires even when no sequencer starts. With `fw_owner_i` low, neither pulse fires.
- R7: After a start strobe, the block issues no further strobe until the matching done arrives: `full_done_i` for full sequences, `idle_done_i` for idle sequences. A done from the other sequencer is ignored.
- R8: Requests that arrive while the block is busy are held in a single slot, and the latest one replaces any earlier one. If both request pulses arrive in the same cycle, D0 is kept.
- R9: After reset, all strobes and `d0_pending_o` are low, and the arm and defer flags are clear.
- R10: At most one start strobe is high in any cycle, and each strobe lasts exactly one cycle. With `fw_owner_i` low, the strobe appears two clock edges after the request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d0_req_i | input | 1 | D0 request pulse |
| d3_req_i | input | 1 | D3 request pulse |
| arm_set_i | input | 1 | Sets the one-shot arm bit |
| defer_set_i | input | 1 | Sets the defer flag |
| fw_owner_i | input | 1 | Configuration space owned by firmware; enables save and restore pulses |
| entry_type_i | input | CODE_W | Idle entry type code |
| exit_type_i | input | CODE_W | Idle exit type code |
| full_done_i | input | 1 | Full sequencer finished |
| idle_done_i | input | 1 | Idle sequencer finished |
| full_off_start_o | output | 1 | Start full power-off |
| full_on_start_o | output | 1 | Start full power-on |
| idle_in_start_o | output | 1 | Start idle entry |
| idle_out_start_o | output | 1 | Start idle exit |
| cfg_save_o | output | 1 | Save configuration space |
| cfg_restore_o | output | 1 | Restore configuration space |
| d0_pending_o | output | 1 | A D3 action ran and a D0 is now allowed |

## Verification
The bench walks a sequence of requests that probes each corner case, and each one catches a specific kind of wrong design:
- **Arm bit not one-shot.** A second unarmed D3 is sent. A design that never clears the arm bit would power off twice.
- **Defer flag cleared too early.** Two D3 requests are sent while the defer flag is set. A design that clears the flag on entry would fall back to full power-off on the second one.
- **Defer flag not cleared on a mismatched exit.** A D0 is sent with a non-matching exit code, followed by another D3. A design that keeps the flag would start idle entry instead of full power-off.
- **Save fired only on a start.** A D3 is sent whose entry code matches neither accepted value. The save pulse must still fire, so a design that ties it to a started sequencer would miss it.
- **Wrong done accepted, or wrong request kept.** While a full power-off is in flight, the bench sends the wrong done and queues D3 then D0. A design that leaves the wait on any done would start early, and one that keeps the first queued request would start nothing.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FULL_OFF,
    ACT_FULL_ON,
    ACT_IDLE_IN,
    ACT_IDLE_OUT
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CFG,
    ST_GO,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/dpd_req_slot.sv
module dpd_req_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d0_req_i,
  input  logic d3_req_i,
  input  logic take_i,
  output logic valid_o,
  output logic is_d0_o
);
  logic valid_q, d0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      d0_q    <= 1'b0;
    end else if (d0_req_i || d3_req_i) begin
      valid_q <= 1'b1;
      d0_q    <= d0_req_i;  // D0 kept on a tie
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign is_d0_o = d0_q;

  a_r8_latest_d0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d0_req_i |=> (valid_o && is_d0_o));
  a_r8_latest_d3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d3_req_i && !d0_req_i) |=> (valid_o && !is_d0_o));
endmodule

// File: rtl/dpd_decide.sv
module dpd_decide
  import dpd_pkg::*;
#(
  parameter int unsigned       CODE_W    = 2,
  parameter logic [CODE_W-1:0] ENTRY_A   = 1,
  parameter logic [CODE_W-1:0] ENTRY_B   = 2,
  parameter logic [CODE_W-1:0] EXIT_CODE = 3
) (
  input  logic              is_d0_i,
  input  logic              arm_i,
  input  logic              defer_i,
  input  logic              pend_i,
  input  logic [CODE_W-1:0] entry_i,
  input  logic [CODE_W-1:0] exit_i,
  output logic              accept_o,
  output act_e              act_o,
  output logic              clr_arm_o,
  output logic              set_pend_o,
  output logic              clr_pend_o,
  output logic              clr_defer_o
);
  logic entry_ok, exit_ok;

  assign entry_ok = (entry_i == ENTRY_A) || (entry_i == ENTRY_B);
  assign exit_ok  = (exit_i == EXIT_CODE);

  always_comb begin
    accept_o    = 1'b0;
    act_o       = ACT_NONE;
    clr_arm_o   = 1'b0;
    set_pend_o  = 1'b0;
    clr_pend_o  = 1'b0;
    clr_defer_o = 1'b0;
    if (is_d0_i) begin
      if (pend_i) begin
        accept_o   = 1'b1;
        clr_pend_o = 1'b1;
        if (defer_i) begin
          clr_defer_o = 1'b1;
          act_o       = exit_ok ? ACT_IDLE_OUT : ACT_NONE;
        end else begin
          act_o = ACT_FULL_ON;
        end
      end
    end else if (arm_i) begin
      accept_o   = 1'b1;
      clr_arm_o  = 1'b1;
      set_pend_o = 1'b1;
      // defer flag deliberately untouched here
      if (defer_i) act_o = entry_ok ? ACT_IDLE_IN : ACT_NONE;
      else         act_o = ACT_FULL_OFF;
    end
  end
endmodule

// File: rtl/dpd_flags.sv
module dpd_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_set_i,
  input  logic defer_set_i,
  input  logic take_i,
  input  logic clr_arm_i,
  input  logic set_pend_i,
  input  logic clr_pend_i,
  input  logic clr_defer_i,
  output logic arm_o,
  output logic defer_o,
  output logic pend_o
);
  logic arm_q, defer_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      defer_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (arm_set_i)                  arm_q <= 1'b1;
      else if (take_i && clr_arm_i)   arm_q <= 1'b0;
      if (defer_set_i)                defer_q <= 1'b1;
      else if (take_i && clr_defer_i) defer_q <= 1'b0;
      if (take_i && set_pend_i)       pend_q <= 1'b1;
      else if (take_i && clr_pend_i)  pend_q <= 1'b0;
    end
  end

  assign arm_o   = arm_q;
  assign defer_o = defer_q;
  assign pend_o  = pend_q;

  a_r1_arm_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && clr_arm_i && !arm_set_i) |=> !arm_o);
  a_r2_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && set_pend_i) |=> pend_o);
  a_r4_defer_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && clr_defer_i && !defer_set_i) |=> !defer_o);
endmodule

// File: rtl/dpd_dispatch.sv
module dpd_dispatch
  import dpd_pkg::*;
#(
  parameter int unsigned       CODE_W    = 2,
  parameter logic [CODE_W-1:0] ENTRY_A   = 1,
  parameter logic [CODE_W-1:0] ENTRY_B   = 2,
  parameter logic [CODE_W-1:0] EXIT_CODE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d0_req_i,
  input  logic              d3_req_i,
  input  logic              arm_set_i,
  input  logic              defer_set_i,
  input  logic              fw_owner_i,
  input  logic [CODE_W-1:0] entry_type_i,
  input  logic [CODE_W-1:0] exit_type_i,
  input  logic              full_done_i,
  input  logic              idle_done_i,
  output logic              full_off_start_o,
  output logic              full_on_start_o,
  output logic              idle_in_start_o,
  output logic              idle_out_start_o,
  output logic              cfg_save_o,
  output logic              cfg_restore_o,
  output logic              d0_pending_o
);
  st_e  state_q, state_d;
  act_e act_q, act_dec;
  logic d0_q;
  logic slot_valid, slot_d0, take;
  logic accept, clr_arm, set_pend, clr_pend, clr_defer;
  logic arm, defer, pend;
  logic full_op, done_match;
  logic [3:0] starts;

  assign take = (state_q == ST_IDLE) && slot_valid;

  dpd_req_slot u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d0_req_i (d0_req_i),
    .d3_req_i (d3_req_i),
    .take_i   (take),
    .valid_o  (slot_valid),
    .is_d0_o  (slot_d0)
  );

  dpd_decide #(
    .CODE_W    (CODE_W),
    .ENTRY_A   (ENTRY_A),
    .ENTRY_B   (ENTRY_B),
    .EXIT_CODE (EXIT_CODE)
  ) u_decide (
    .is_d0_i     (slot_d0),
    .arm_i       (arm),
    .defer_i     (defer),
    .pend_i      (pend),
    .entry_i     (entry_type_i),
    .exit_i      (exit_type_i),
    .accept_o    (accept),
    .act_o       (act_dec),
    .clr_arm_o   (clr_arm),
    .set_pend_o  (set_pend),
    .clr_pend_o  (clr_pend),
    .clr_defer_o (clr_defer)
  );

  dpd_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_set_i   (arm_set_i),
    .defer_set_i (defer_set_i),
    .take_i      (take),
    .clr_arm_i   (clr_arm),
    .set_pend_i  (set_pend),
    .clr_pend_i  (clr_pend),
    .clr_defer_i (clr_defer),
    .arm_o       (arm),
    .defer_o     (defer),
    .pend_o      (pend)
  );

  assign full_op    = (act_q == ACT_FULL_OFF) || (act_q == ACT_FULL_ON);
  assign done_match = full_op ? full_done_i : idle_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take && accept) state_d = fw_owner_i ? ST_CFG : ST_GO;
      ST_CFG:  state_d = ST_GO;
      ST_GO:   state_d = (act_q == ACT_NONE) ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (done_match) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= ACT_NONE;
      d0_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take && accept) begin
        act_q <= act_dec;
        d0_q  <= slot_d0;
      end
    end
  end

  assign full_off_start_o = (state_q == ST_GO) && (act_q == ACT_FULL_OFF);
  assign full_on_start_o  = (state_q == ST_GO) && (act_q == ACT_FULL_ON);
  assign idle_in_start_o  = (state_q == ST_GO) && (act_q == ACT_IDLE_IN);
  assign idle_out_start_o = (state_q == ST_GO) && (act_q == ACT_IDLE_OUT);
  assign cfg_save_o       = (state_q == ST_CFG) && !d0_q;
  assign cfg_restore_o    = (state_q == ST_CFG) && d0_q;
  assign d0_pending_o     = pend;

  assign starts = {idle_out_start_o, idle_in_start_o, full_on_start_o, full_off_start_o};

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(starts));
  a_r10_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|starts) |=> !(|starts));
  a_r6_cfg_then_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_save_o || cfg_restore_o) |=> (state_q == ST_GO));
  a_r6_no_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && accept && !fw_owner_i) |=> !(cfg_save_o || cfg_restore_o));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !done_match) |=> (state_q == ST_WAIT));
  a_r2_d0_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && slot_d0 && !pend) |=> (state_q == ST_IDLE));
  a_r5_defer_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !slot_d0 && defer) |=> defer);
endmodule

// File: tb/dpd_dispatch_tb.sv
`timescale 1ns/1ps
module dpd_dispatch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d0_req = 0, d3_req = 0, arm_set = 0, defer_set = 0, fw = 0;
  logic [1:0] entry_t = 0, exit_t = 0;
  logic full_done = 0, idle_done = 0;
  logic foff, fon, iin, iout, sv, rs, pend;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dpd_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .d0_req_i(d0_req), .d3_req_i(d3_req),
    .arm_set_i(arm_set), .defer_set_i(defer_set), .fw_owner_i(fw),
    .entry_type_i(entry_t), .exit_type_i(exit_t),
    .full_done_i(full_done), .idle_done_i(idle_done),
    .full_off_start_o(foff), .full_on_start_o(fon),
    .idle_in_start_o(iin), .idle_out_start_o(iout),
    .cfg_save_o(sv), .cfg_restore_o(rs), .d0_pending_o(pend)
  );

  // [15] d0, [14] arm, [13] defer set, [12:11] entry, [10:9] exit, [8] fw,
  // [7] save, [6] restore, [5:2] start {iout,iin,fon,foff}, [1] pending
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b0,4'b0000,1'b0,1'b0},
    {1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b0,4'b0000,1'b0,1'b0},
    {1'b0,1'b1,1'b0,2'd0,2'd0,1'b1,1'b1,1'b0,4'b0001,1'b1,1'b0},
    {1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b0,4'b0000,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b1,4'b0010,1'b0,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b0,4'b0000,1'b0,1'b0},
    {1'b0,1'b1,1'b1,2'd1,2'd0,1'b0,1'b0,1'b0,4'b0100,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd3,1'b0,1'b0,1'b0,4'b1000,1'b0,1'b0},
    {1'b0,1'b1,1'b0,2'd1,2'd0,1'b0,1'b0,1'b0,4'b0001,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,1'b1,2'd0,2'd0,1'b1,1'b1,1'b0,4'b0000,1'b1,1'b0},
    {1'b0,1'b1,1'b0,2'd2,2'd0,1'b0,1'b0,1'b0,4'b0100,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd1,1'b1,1'b0,1'b1,4'b0000,1'b0,1'b0},
    {1'b0,1'b1,1'b0,2'd2,2'd0,1'b0,1'b0,1'b0,4'b0001,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,1'b1,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,1'b1,2'd3,2'd0,1'b0,1'b0,1'b0,4'b0000,1'b1,1'b0},
    {1'b1,1'b0,1'b0,2'd0,2'd3,1'b0,1'b0,1'b0,4'b1000,1'b0,1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic s_seen, r_seen;
    logic [3:0] st_seen;
    int st_cnt, cfg_at, st_at;
    s_seen = 0; r_seen = 0; st_seen = 0; st_cnt = 0; cfg_at = -1; st_at = -1;
    @(negedge clk);
    arm_set = v[14]; defer_set = v[13]; entry_t = v[12:11]; exit_t = v[10:9]; fw = v[8];
    @(negedge clk);
    arm_set = 0; defer_set = 0;
    if (v[15]) d0_req = 1; else d3_req = 1;
    @(negedge clk);
    d0_req = 0; d3_req = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      full_done = 0; idle_done = 0;
      if (sv || rs) cfg_at = i;
      s_seen |= sv; r_seen |= rs;
      if (foff || fon || iin || iout) begin
        st_cnt++;
        if (st_at < 0) st_at = i;
      end
      st_seen |= {iout, iin, fon, foff};
      if (st_at >= 0 && i == st_at + 1) begin
        if (st_seen[1:0] != 0) full_done = 1; else idle_done = 1;
      end
    end
    @(negedge clk);
    full_done = 0; idle_done = 0;
    chk(s_seen == v[7], "R6 save", s_seen, v[7]);
    chk(r_seen == v[6], "R6 restore", r_seen, v[6]);
    chk(st_seen == v[5:2], "R1 R3 R4 R5 start", st_seen, v[5:2]);
    chk(st_cnt == ((v[5:2] != 0) ? 1 : 0), "R10 strobe width", st_cnt, (v[5:2] != 0) ? 1 : 0);
    chk(pend == v[1], "R2 pending", pend, v[1]);
    if ((v[7] || v[6]) && v[5:2] != 0)
      chk(cfg_at >= 0 && cfg_at + 1 == st_at, "R6 order", cfg_at, st_at - 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic bad;
    logic got;
    do_reset();
    // R9 reset state
    chk({foff, fon, iin, iout, sv, rs, pend} == 7'd0, "R9 reset outputs",
        {foff, fon, iin, iout, sv, rs, pend}, 0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R7, R8: wait holds, wrong done ignored, latest queued request wins
    do_reset();
    fw = 0;
    @(negedge clk); arm_set = 1;
    @(negedge clk); arm_set = 0; d3_req = 1;
    @(negedge clk); d3_req = 0;
    @(negedge clk);
    chk(foff == 1, "R10 full off latency", foff, 1);
    @(negedge clk); idle_done = 1; d3_req = 1;
    @(negedge clk); idle_done = 0; d3_req = 0; d0_req = 1;
    @(negedge clk); d0_req = 0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bad |= foff | fon | iin | iout | sv | rs;
    end
    chk(!bad, "R7 hold in wait", bad, 0);
    full_done = 1;
    @(negedge clk); full_done = 0;
    got = 0; bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      full_done = 0;
      if (fon) begin got = 1; full_done = 1; end
      bad |= foff | iin | iout;
    end
    @(negedge clk); full_done = 0;
    chk(got && !bad, "R8 latest request", {got, bad}, 2);
    chk(pend == 0, "R2 pending cleared", pend, 0);

    // R9 mid-run reset clears arm and pending
    @(negedge clk); arm_set = 1;
    @(negedge clk); arm_set = 0;
    do_reset();
    chk(pend == 0, "R9 pending after reset", pend, 0);
    @(negedge clk); d3_req = 1;
    @(negedge clk); d3_req = 0;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bad |= foff | fon | iin | iout;
    end
    chk(!bad && pend == 0, "R9 arm cleared by reset", {bad, pend}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule